// File: doc/BRIEF.md
# Packed saturating arithmetic unit

A purely combinational arithmetic slice that adds or subtracts two data words with saturation instead of wrap-around. It serves the execute stage of a processor datapath that already holds the sticky saturation flag. That flag register, instruction decoding and operand shifting all sit outside this block. A 4-bit operation code picks one of four families. The first is a whole-word signed add or subtract. The second is a doubling form that first saturates twice the second operand and then adds it to, or subtracts it from, the first. The third treats the word as four quarter-width lanes or two half-width lanes, signed or unsigned. The fourth is a signed exchange form that pairs each half of the first operand with the opposite half of the second.

Every lane clamps to its own range. Only the whole-word and doubling forms can raise the saturation-set output. That output is a one-shot request to set the sticky flag. The block never asks for the flag to be cleared. The data width is a parameter, and the lane widths are a quarter and a half of it.

Top module: `psat_unit`

## Requirements
- R1: Codes 1 (add) and 2 (subtract) treat the whole word as a two's-complement number. A result beyond the representable range is clamped to the nearest limit, and qset_o is 1 exactly when clamping occurred.
- R2: Codes 3 (doubling add) and 4 (doubling subtract) first form d = b + b, saturated to the signed word range. They then return a + d (code 3) or a - d (code 4), saturated again. qset_o is 1 when either step clamps.
- R3: Codes 5 (add) and 6 (subtract) work on four signed quarter-width lanes, lane i occupying bits [(i+1)*W/4-1 : i*W/4]. Each lane clamps to its own signed range.
- R4: Codes 7 (add) and 8 (subtract) work on two signed half-width lanes, low half in bits [W/2-1:0]. Each lane clamps to its own signed range.
- R5: Codes 9/10 (quarter lanes, add/subtract) and 11/12 (half lanes, add/subtract) are unsigned. Each lane clamps to the range 0 to 2^w-1, where w is the lane width.
- R6: Code 13 is signed and per half: low result = a.low - b.high and high result = a.high + b.low, each saturated.
- R7: Code 14 is signed and per half: low result = a.low + b.high and high result = a.high - b.low, each saturated.
- R8: For codes 5 to 14, qset_o stays 0 whatever the operands.
- R9: Codes 0 and 15 are unused. They return a zero result with qset_o at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code, encoding as listed in the requirements |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| res_o | output | W | Saturated result |
| qset_o | output | 1 | Request to set the sticky saturation flag |

## Verification
The bench builds the unit with W = 8. That makes the quarter lanes 2 bits wide and the half lanes 4 bits wide, so every lane limit is a handful of values away. For each of the sixteen codes it sweeps all 256 first operands against 32 second operands. The second-operand set includes both ends of the range, so every positive and negative clamp, the doubling pre-clamp and the unsigned borrow case are reached many times. A small integer model in the bench computes each lane's expected value and the expected saturation request.

// File: rtl/psat_pkg.sv
package psat_pkg;

  typedef enum logic [3:0] {
    OP_RSV0   = 4'd0,
    OP_WADD   = 4'd1,
    OP_WSUB   = 4'd2,
    OP_WDADD  = 4'd3,
    OP_WDSUB  = 4'd4,
    OP_QSADD  = 4'd5,
    OP_QSSUB  = 4'd6,
    OP_HSADD  = 4'd7,
    OP_HSSUB  = 4'd8,
    OP_QUADD  = 4'd9,
    OP_QUSUB  = 4'd10,
    OP_HUADD  = 4'd11,
    OP_HUSUB  = 4'd12,
    OP_XLSUB  = 4'd13,
    OP_XLADD  = 4'd14,
    OP_RSV15  = 4'd15
  } psat_op_e;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_WORD = 2'd1,
    SEL_QTR  = 2'd2,
    SEL_HALF = 2'd3
  } psat_sel_e;

endpackage

// File: rtl/psat_lane.sv
module psat_lane #(
  parameter int LW = 8
) (
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  input  logic          sub_i,
  input  logic          signed_i,
  output logic [LW-1:0] res_o,
  output logic          clamp_o
);

  localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};
  localparam logic [LW-1:0] SMAX = ~SMIN;
  localparam logic [LW-1:0] UMAX = {LW{1'b1}};

  logic [LW:0] ext_a;
  logic [LW:0] ext_b;
  logic [LW:0] full;

  always_comb begin
    ext_a = {signed_i & a_i[LW-1], a_i};
    ext_b = {signed_i & b_i[LW-1], b_i};
    full  = sub_i ? (ext_a - ext_b) : (ext_a + ext_b);
    if (signed_i) begin
      clamp_o = full[LW] ^ full[LW-1];
      if (clamp_o) res_o = full[LW] ? SMIN : SMAX;
      else         res_o = full[LW-1:0];
    end else begin
      clamp_o = full[LW];
      if (clamp_o) res_o = sub_i ? '0 : UMAX;
      else         res_o = full[LW-1:0];
    end

    // R1/R3: signed sum of opposite signs cannot leave the range
    if (signed_i && !sub_i && (a_i[LW-1] != b_i[LW-1]))
      p_no_mixed_add_clamp_r3: assert (!clamp_o);
    // R1/R3: signed difference of equal signs cannot leave the range
    if (signed_i && sub_i && (a_i[LW-1] == b_i[LW-1]))
      p_no_same_sub_clamp_r1: assert (!clamp_o);
    // R5: unsigned subtract without borrow never clamps
    if (!signed_i && sub_i && (a_i >= b_i))
      p_no_borrow_clamp_r5: assert (!clamp_o);
  end

endmodule

// File: rtl/psat_lanes.sv
module psat_lanes #(
  parameter int W  = 32,
  parameter int LW = 8
) (
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [W/LW-1:0]   sub_i,
  input  logic              signed_i,
  output logic [W-1:0]      res_o
);

  localparam int NL = W / LW;

  logic [NL-1:0] clamp;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    psat_lane #(.LW(LW)) u_lane (
      .a_i      (a_i[g*LW +: LW]),
      .b_i      (b_i[g*LW +: LW]),
      .sub_i    (sub_i[g]),
      .signed_i (signed_i),
      .res_o    (res_o[g*LW +: LW]),
      .clamp_o  (clamp[g])
    );
  end

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      // R5: an unsigned lane that clamps on add sits at its upper limit
      if (!signed_i && !sub_i[i] && clamp[i])
        p_uadd_clamp_top_r5: assert (res_o[i*LW +: LW] == {LW{1'b1}});
    end
  end

endmodule

// File: rtl/psat_word.sv
module psat_word #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         dbl_i,
  output logic [W-1:0] res_o,
  output logic         qset_o
);

  logic [W-1:0] twice;
  logic [W-1:0] second;
  logic         pre_clamp;
  logic         post_clamp;

  psat_lane #(.LW(W)) u_double (
    .a_i      (b_i),
    .b_i      (b_i),
    .sub_i    (1'b0),
    .signed_i (1'b1),
    .res_o    (twice),
    .clamp_o  (pre_clamp)
  );

  assign second = dbl_i ? twice : b_i;

  psat_lane #(.LW(W)) u_final (
    .a_i      (a_i),
    .b_i      (second),
    .sub_i    (sub_i),
    .signed_i (1'b1),
    .res_o    (res_o),
    .clamp_o  (post_clamp)
  );

  assign qset_o = post_clamp | (dbl_i & pre_clamp);

  always_comb begin
    // R2: doubling a value in the inner half of the range never clamps
    if (dbl_i && (b_i[W-1] == b_i[W-2]))
      p_double_inner_r2: assert (!pre_clamp);
    // R2: a clamped doubling keeps the sign of b
    if (dbl_i && pre_clamp)
      p_double_sign_r2: assert (twice[W-1] == b_i[W-1]);
  end

endmodule

// File: rtl/psat_unit.sv
module psat_unit
  import psat_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         qset_o
);

  localparam int QW = W / 4;
  localparam int HW = W / 2;
  localparam int NQ = W / QW;
  localparam int NH = W / HW;

  psat_op_e      op;
  psat_sel_e     sel;
  logic          w_sub;
  logic          w_dbl;
  logic          q_sub;
  logic          q_sgn;
  logic [NH-1:0] h_sub;
  logic          h_sgn;
  logic          h_swap;
  logic [W-1:0]  h_b;
  logic [W-1:0]  w_res;
  logic          w_q;
  logic [W-1:0]  q_res;
  logic [W-1:0]  h_res;

  assign op = psat_op_e'(op_i);

  always_comb begin
    sel    = SEL_ZERO;
    w_sub  = 1'b0;
    w_dbl  = 1'b0;
    q_sub  = 1'b0;
    q_sgn  = 1'b1;
    h_sub  = '0;
    h_sgn  = 1'b1;
    h_swap = 1'b0;
    unique case (op)
      OP_WADD:  begin sel = SEL_WORD; end
      OP_WSUB:  begin sel = SEL_WORD; w_sub = 1'b1; end
      OP_WDADD: begin sel = SEL_WORD; w_dbl = 1'b1; end
      OP_WDSUB: begin sel = SEL_WORD; w_dbl = 1'b1; w_sub = 1'b1; end
      OP_QSADD: begin sel = SEL_QTR; end
      OP_QSSUB: begin sel = SEL_QTR; q_sub = 1'b1; end
      OP_HSADD: begin sel = SEL_HALF; end
      OP_HSSUB: begin sel = SEL_HALF; h_sub = '1; end
      OP_QUADD: begin sel = SEL_QTR; q_sgn = 1'b0; end
      OP_QUSUB: begin sel = SEL_QTR; q_sgn = 1'b0; q_sub = 1'b1; end
      OP_HUADD: begin sel = SEL_HALF; h_sgn = 1'b0; end
      OP_HUSUB: begin sel = SEL_HALF; h_sgn = 1'b0; h_sub = '1; end
      OP_XLSUB: begin sel = SEL_HALF; h_swap = 1'b1; h_sub = 2'b01; end
      OP_XLADD: begin sel = SEL_HALF; h_swap = 1'b1; h_sub = 2'b10; end
      default:  begin sel = SEL_ZERO; end
    endcase
  end

  assign h_b = h_swap ? {b_i[HW-1:0], b_i[W-1:HW]} : b_i;

  psat_word #(.W(W)) u_word (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (w_sub),
    .dbl_i  (w_dbl),
    .res_o  (w_res),
    .qset_o (w_q)
  );

  psat_lanes #(.W(W), .LW(QW)) u_qtr (
    .a_i      (a_i),
    .b_i      (b_i),
    .sub_i    ({NQ{q_sub}}),
    .signed_i (q_sgn),
    .res_o    (q_res)
  );

  psat_lanes #(.W(W), .LW(HW)) u_half (
    .a_i      (a_i),
    .b_i      (h_b),
    .sub_i    (h_sub),
    .signed_i (h_sgn),
    .res_o    (h_res)
  );

  always_comb begin
    unique case (sel)
      SEL_WORD: begin res_o = w_res; qset_o = w_q;  end
      SEL_QTR:  begin res_o = q_res; qset_o = 1'b0; end
      SEL_HALF: begin res_o = h_res; qset_o = 1'b0; end
      default:  begin res_o = '0;    qset_o = 1'b0; end
    endcase

    // R8: lane and exchange codes never request the sticky flag
    if (op_i >= 4'd5)
      p_lane_no_qset_r8: assert (!qset_o);
    // R9: unused codes give an all-zero result
    if ((op_i == 4'd0) || (op_i == 4'd15))
      p_unused_zero_r9: assert ((res_o == '0) && !qset_o);
  end

endmodule

// File: tb/psat_unit_test.sv
`timescale 1ns/1ps
module psat_unit_test;

  localparam int W  = 8;
  localparam int QW = W / 4;
  localparam int HW = W / 2;

  logic         clk;
  logic [3:0]   op;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic [W-1:0] res;
  logic         qset;

  int checks;
  int errors;
  int cycles;
  bit done;

  psat_unit #(.W(W)) uut (
    .op_i   (op),
    .a_i    (a),
    .b_i    (b),
    .res_o  (res),
    .qset_o (qset)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int sx(int v, int w);
    int m;
    m = v & ((1 << w) - 1);
    return (m >= (1 << (w - 1))) ? m - (1 << w) : m;
  endfunction

  function automatic int lane(int x, int y, bit sub, bit sgn, int w, output bit c);
    int xv, yv, r, hi, lo;
    xv = sgn ? sx(x, w) : (x & ((1 << w) - 1));
    yv = sgn ? sx(y, w) : (y & ((1 << w) - 1));
    r  = sub ? xv - yv : xv + yv;
    hi = sgn ? (1 << (w - 1)) - 1 : (1 << w) - 1;
    lo = sgn ? -(1 << (w - 1)) : 0;
    c  = 1'b0;
    if (r > hi) begin r = hi; c = 1'b1; end
    if (r < lo) begin r = lo; c = 1'b1; end
    return r & ((1 << w) - 1);
  endfunction

  task automatic model(input int o, input int x, input int y, output int er, output bit eq);
    bit c1, c2;
    int d, lo, hi;
    er = 0; eq = 1'b0;
    case (o)
      1, 2: begin er = lane(x, y, o == 2, 1'b1, W, c1); eq = c1; end
      3, 4: begin
        d  = lane(y, y, 1'b0, 1'b1, W, c1);
        er = lane(x, d, o == 4, 1'b1, W, c2);
        eq = c1 | c2;
      end
      5, 6, 9, 10: begin
        for (int i = 0; i < 4; i++)
          er |= lane(x >> (i*QW), y >> (i*QW), (o == 6) || (o == 10), o < 9, QW, c1) << (i*QW);
      end
      7, 8, 11, 12: begin
        for (int i = 0; i < 2; i++)
          er |= lane(x >> (i*HW), y >> (i*HW), (o == 8) || (o == 12), o < 9, HW, c1) << (i*HW);
      end
      13, 14: begin
        lo = lane(x, y >> HW, o == 13, 1'b1, HW, c1);
        hi = lane(x >> HW, y, o == 14, 1'b1, HW, c2);
        er = (hi << HW) | lo;
      end
      default: er = 0;
    endcase
  endtask

  function automatic string tag(int o, bit qbad);
    if (qbad && (o >= 5) && (o <= 14)) return "R8";
    case (o)
      1, 2:          return "R1";
      3, 4:          return "R2";
      5, 6:          return "R3";
      7, 8:          return "R4";
      9, 10, 11, 12: return "R5";
      13:            return "R6";
      14:            return "R7";
      default:       return "R9";
    endcase
  endfunction

  task automatic apply(input int o, input int x, input int y);
    int er;
    bit eq;
    op = 4'(o); a = W'(x); b = W'(y);
    #1;
    model(o, x, y, er, eq);
    checks++;
    if ((int'(res) != er) || (qset != eq)) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h: got res=%h q=%b, expected res=%h q=%b",
               tag(o, qset != eq), o, x, y, res, qset, W'(er), eq);
    end
  endtask

  function automatic int pick_b(int j);
    if (j < 8)   return j;
    if (j >= 24) return 224 + j;
    return (j * 11) & 255;
  endfunction

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    // R9: idle code at start gives zero
    apply(0, 8'h7f, 8'h7f);
    // R1 directed: positive and negative word clamps
    apply(1, 8'h7f, 8'h01);
    apply(2, 8'h80, 8'h01);
    // R2 directed: pre-clamp of 2*b alone sets qset
    apply(3, 8'h00, 8'h40);
    // R6/R7 directed exchange corners
    apply(13, 8'h78, 8'h17);
    apply(14, 8'h87, 8'h71);
    for (int o = 0; o < 16; o++)
      for (int x = 0; x < 256; x++)
        for (int j = 0; j < 32; j++)
          apply(o, x, pick_b(j));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cycles = 0;
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule